// File: doc/BRIEF.md
# Dual-Frequency Numerically Controlled Oscillator

This block synthesises a digital sine wave, one sample per clock. A 32-bit phase accumulator advances on every clock by one of two frequency tuning words, chosen by a one-bit frequency select. The output frequency is therefore tuning word × f_clk / 2^32. The top 12 bits of the accumulator are added to one of four 12-bit phase offsets, chosen by a two-bit phase select. The 12-bit sum addresses a sine table, which returns a 10-bit offset-binary amplitude for a downstream converter.

The selects can switch on any clock, so the block produces frequency-shift and phase-shift keyed carriers directly from a modulating bit stream. The tuning and offset words are plain inputs, held by whatever register file sits around the block. Every control and data input takes the same fixed path to the output. A stall input freezes the whole pipeline, and the output holds its last sample while it is high.

Top module: `dual_freq_nco`

## Requirements
- R1: The phase accumulator is 32 bits wide, wraps modulo 2^32 and advances by the selected tuning word on every clock where `hold` is low. A word of 0x4000_0000 gives an output that repeats every 4 samples.
- R2: `fsel` = 0 selects `freq_word0` as the step and `fsel` = 1 selects `freq_word1`.
- R3: Changing `fsel` or a tuning word changes only the step size. The accumulated phase carries on from its current value with no jump.
- R4: `psel` values 0, 1, 2 and 3 (bit 1 the MSB) select `phase_word0`, `phase_word1`, `phase_word2` and `phase_word3` respectively.
- R5: The selected offset is added, modulo 4096, to accumulator bits [31:20]. One offset LSB is 2π/4096 of phase.
- R6: For a 12-bit phase p, the sample is 512 + round(511·sin(2π·p/4096)), with halves rounded away from zero. So p = 0 gives 512, p = 1024 gives 1023, p = 2048 gives 512 and p = 3072 gives 1. The sample is never 0.
- R7: Inputs are sampled on the rising clock edge. A value sampled at edge N first shows on `sample` just after edge N+5, which is six register stages. Selects, tuning words and offset words all take this path.
- R8: While `rst_n` is low, the accumulator and every pipeline stage are cleared and `sample` reads 512 (midscale). After release, zero tuning and offset words keep `sample` at 512.
- R9: While `hold` is high at a rising edge, no stage updates: the accumulator keeps its value, `sample` keeps its last value, and inputs at that edge are ignored. When `hold` falls, operation resumes from the frozen phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold | input | 1 | Freezes all stages while high |
| fsel | input | 1 | Tuning word select |
| psel | input | 2 | Phase offset select |
| freq_word0 | input | 32 | Tuning word 0 |
| freq_word1 | input | 32 | Tuning word 1 |
| phase_word0 | input | 12 | Phase offset 0 |
| phase_word1 | input | 12 | Phase offset 1 |
| phase_word2 | input | 12 | Phase offset 2 |
| phase_word3 | input | 12 | Phase offset 3 |
| sample | output | 10 | Offset-binary sine amplitude |

## Verification
The assertions assume that `rst_n` is low from time zero until some clock edges have passed. They also assume that `hold`, the selects and all words are settled at each rising edge, so that each one is sampled at one definite edge. The stimulus changes every input only on the falling clock edge, and it starts each scenario from a fresh reset. The bench's reference model can therefore count which rising edge saw each value and predict every sample.

// File: rtl/nco_pkg.sv
package nco_pkg;

  // pi scaled by 2^30
  localparam longint PI_Q30 = 64'sd3373259426;

  // Magnitude of peak*sin(k*pi/(2*qtr)) for k in [0, qtr], rounded to nearest
  function automatic int nco_sin_mag(input int k, input int qtr, input int peak);
    longint x;
    longint x2;
    longint term;
    longint acc;
    longint scaled;
    x    = (longint'(k) * PI_Q30) / longint'(2 * qtr);
    x2   = (x * x) >>> 30;
    term = x;
    acc  = x;
    for (int n = 1; n <= 7; n++) begin
      term = (term * x2) >>> 30;
      term = -(term / longint'((2 * n) * (2 * n + 1)));
      acc  = acc + term;
    end
    if (acc < 0) acc = 0;
    scaled = (longint'(peak) * acc + (64'sd1 <<< 29)) >>> 30;
    return int'(scaled);
  endfunction

endpackage

// File: rtl/nco_select.sv
module nco_select #(
  parameter int ACC_W  = 32,
  parameter int PH_W   = 12,
  parameter int NUM_FW = 2,
  parameter int NUM_PH = 4,
  localparam int FS_W  = (NUM_FW > 1) ? $clog2(NUM_FW) : 1,
  localparam int PS_W  = (NUM_PH > 1) ? $clog2(NUM_PH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_i,
  input  logic [FS_W-1:0]  fsel_i,
  input  logic [PS_W-1:0]  psel_i,
  input  logic [ACC_W-1:0] fw_i [NUM_FW],
  input  logic [PH_W-1:0]  pw_i [NUM_PH],
  output logic [ACC_W-1:0] step_q,
  output logic [PH_W-1:0]  ofs_q
);

  // Stage 1: sample the selects and capture the chosen words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      ofs_q  <= '0;
    end else if (!hold_i) begin
      step_q <= fw_i[fsel_i];
      ofs_q  <= pw_i[psel_i];
    end
  end

  // R9
  sel_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> ($stable(step_q) && $stable(ofs_q)));

endmodule

// File: rtl/nco_phase_accum.sv
module nco_phase_accum #(
  parameter int ACC_W = 32,
  parameter int PH_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_i,
  input  logic [ACC_W-1:0] step_i,
  input  logic [PH_W-1:0]  ofs_i,
  output logic [PH_W-1:0]  phase_q
);

  logic [ACC_W-1:0] acc_q;
  logic [PH_W-1:0]  ofs_d;

  // Stage 2: accumulate; delay the offset to stay aligned with the accumulator
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ofs_d <= '0;
    end else if (!hold_i) begin
      acc_q <= acc_q + step_i;
      ofs_d <= ofs_i;
    end
  end

  // Stage 3: truncate to the table width and add the phase offset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (!hold_i) begin
      phase_q <= acc_q[ACC_W-1 -: PH_W] + ofs_d;
    end
  end

  // R1
  zero_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_i && step_i == '0) |=> $stable(acc_q));

  // R9
  acc_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> ($stable(acc_q) && $stable(phase_q)));

endmodule

// File: rtl/nco_sine_lut.sv
module nco_sine_lut #(
  parameter int PH_W  = 12,
  parameter int AMP_W = 10,
  localparam int QTR   = 1 << (PH_W - 2),
  localparam int K_W   = PH_W - 1,
  localparam int MAG_W = AMP_W - 1,
  localparam int PEAK  = (1 << (AMP_W - 1)) - 1,
  localparam int MID   = 1 << (AMP_W - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_i,
  input  logic [PH_W-1:0]  phase_i,
  output logic [AMP_W-1:0] sample_q
);

  logic [MAG_W-1:0] tab [QTR+1];

  // Quarter-wave magnitudes for k = 0 .. QTR, computed at elaboration
  for (genvar k = 0; k <= QTR; k++) begin : g_tab
    localparam int MAGV = nco_pkg::nco_sin_mag(k, QTR, PEAK);
    assign tab[k] = MAG_W'(MAGV);
  end

  logic [K_W-1:0]   k_q;
  logic             neg4_q;
  logic [MAG_W-1:0] mag_q;
  logic             neg5_q;

  // Stage 4: fold the phase into the first quadrant
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_q    <= '0;
      neg4_q <= 1'b0;
    end else if (!hold_i) begin
      neg4_q <= phase_i[PH_W-1];
      if (phase_i[PH_W-2])
        k_q <= K_W'(QTR) - {1'b0, phase_i[PH_W-3:0]};
      else
        k_q <= {1'b0, phase_i[PH_W-3:0]};
    end
  end

  // Stage 5: table read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mag_q  <= '0;
      neg5_q <= 1'b0;
    end else if (!hold_i) begin
      mag_q  <= tab[k_q];
      neg5_q <= neg4_q;
    end
  end

  // Stage 6: apply the half-wave sign around midscale
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_q <= AMP_W'(MID);
    end else if (!hold_i) begin
      if (neg5_q)
        sample_q <= AMP_W'(MID) - {1'b0, mag_q};
      else
        sample_q <= AMP_W'(MID) + {1'b0, mag_q};
    end
  end

  // R6
  lower_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_i && neg5_q) |=> (sample_q <= AMP_W'(MID)));

  // R6
  upper_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_i && !neg5_q) |=> (sample_q >= AMP_W'(MID)));

endmodule

// File: rtl/dual_freq_nco.sv
module dual_freq_nco #(
  parameter int ACC_W = 32,
  parameter int PH_W  = 12,
  parameter int AMP_W = 10,
  localparam int MID  = 1 << (AMP_W - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             fsel,
  input  logic [1:0]       psel,
  input  logic [ACC_W-1:0] freq_word0,
  input  logic [ACC_W-1:0] freq_word1,
  input  logic [PH_W-1:0]  phase_word0,
  input  logic [PH_W-1:0]  phase_word1,
  input  logic [PH_W-1:0]  phase_word2,
  input  logic [PH_W-1:0]  phase_word3,
  output logic [AMP_W-1:0] sample
);

  logic [ACC_W-1:0] fw_arr [2];
  logic [PH_W-1:0]  pw_arr [4];
  logic [ACC_W-1:0] step;
  logic [PH_W-1:0]  ofs;
  logic [PH_W-1:0]  phase;

  assign fw_arr[0] = freq_word0;
  assign fw_arr[1] = freq_word1;
  assign pw_arr[0] = phase_word0;
  assign pw_arr[1] = phase_word1;
  assign pw_arr[2] = phase_word2;
  assign pw_arr[3] = phase_word3;

  nco_select #(
    .ACC_W (ACC_W),
    .PH_W  (PH_W),
    .NUM_FW(2),
    .NUM_PH(4)
  ) u_select (
    .clk   (clk),
    .rst_n (rst_n),
    .hold_i(hold),
    .fsel_i(fsel),
    .psel_i(psel),
    .fw_i  (fw_arr),
    .pw_i  (pw_arr),
    .step_q(step),
    .ofs_q (ofs)
  );

  nco_phase_accum #(
    .ACC_W(ACC_W),
    .PH_W (PH_W)
  ) u_accum (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold_i (hold),
    .step_i (step),
    .ofs_i  (ofs),
    .phase_q(phase)
  );

  nco_sine_lut #(
    .PH_W (PH_W),
    .AMP_W(AMP_W)
  ) u_lut (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold_i  (hold),
    .phase_i (phase),
    .sample_q(sample)
  );

  // R9
  out_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(sample));

  // R6
  never_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample != '0);

  // R8
  reset_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (sample == AMP_W'(MID)));

endmodule

// File: tb/dual_freq_nco_bench.sv
`timescale 1ns/1ps
module dual_freq_nco_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hold = 1'b0;
  logic        fsel = 1'b0;
  logic [1:0]  psel = 2'd0;
  logic [31:0] fw0 = '0;
  logic [31:0] fw1 = '0;
  logic [11:0] pw0 = '0;
  logic [11:0] pw1 = '0;
  logic [11:0] pw2 = '0;
  logic [11:0] pw3 = '0;
  logic [9:0]  sample;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [31:0] cum_h [6];
  logic [11:0] p_h   [6];
  logic [31:0] rng = 32'h1ACE_B00C;

  always #2.5 clk = ~clk;

  dual_freq_nco u_dual_freq_nco (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold       (hold),
    .fsel       (fsel),
    .psel       (psel),
    .freq_word0 (fw0),
    .freq_word1 (fw1),
    .phase_word0(pw0),
    .phase_word1(pw1),
    .phase_word2(pw2),
    .phase_word3(pw3),
    .sample     (sample)
  );

  function automatic int amp_of(input int p);
    real s;
    int  r;
    s = 511.0 * $sin(2.0 * 3.14159265358979 * real'(p) / 4096.0);
    if (s >= 0.0) r = $rtoi(s + 0.5);
    else          r = -$rtoi(-s + 0.5);
    return 512 + r;
  endfunction

  function automatic logic [31:0] next_rng(input logic [31:0] v);
    logic [31:0] t;
    t = v ^ (v << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < 6; i++) begin
      cum_h[i] = '0;
      p_h[i]   = '0;
    end
  endtask

  // One clock: reference model steps on the rising edge, compare at the falling edge
  task automatic cyc(input string tag);
    logic [31:0] f;
    logic [11:0] p;
    logic [11:0] a;
    logic        h;
    f = fsel ? fw1 : fw0;
    case (psel)
      2'd0: p = pw0;
      2'd1: p = pw1;
      2'd2: p = pw2;
      default: p = pw3;
    endcase
    h = hold;
    @(posedge clk);
    if (!rst_n) begin
      clear_model();
    end else if (!h) begin
      for (int i = 5; i > 0; i--) begin
        cum_h[i] = cum_h[i-1];
        p_h[i]   = p_h[i-1];
      end
      cum_h[0] = cum_h[1] + f;
      p_h[0]   = p;
    end
    @(negedge clk);
    a = cum_h[5][31:20] + p_h[5];
    check(tag, int'(sample), amp_of(int'(a)));
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    hold  = 1'b0;
    clear_model();
    #1;
    check("R8", int'(sample), 512);
    repeat (3) @(negedge clk);
    check("R8", int'(sample), 512);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    fw0 = '0; fw1 = '0; pw0 = '0; pw1 = '0; pw2 = '0; pw3 = '0;
    fsel = 1'b0; psel = 2'd0;
    apply_reset();
    repeat (10) cyc("R8");
    check("R8", int'(sample), 512);
  endtask

  task automatic t_phase_select();
    int quad_exp [4];
    quad_exp[0] = 512; quad_exp[1] = 1023; quad_exp[2] = 512; quad_exp[3] = 1;
    fw0 = '0; fw1 = '0;
    pw0 = 12'd0; pw1 = 12'd1024; pw2 = 12'd2048; pw3 = 12'd3072;
    apply_reset();
    for (int s = 0; s < 4; s++) begin
      psel = 2'(s);
      repeat (7) cyc("R4");
      check("R6", int'(sample), quad_exp[s]);
    end
    for (int s = 3; s >= 0; s--) begin
      psel = 2'(s);
      repeat (3) cyc("R4");
    end
    // offset wrap past 4095
    pw0 = 12'd3000; fw0 = 32'h4000_0000; psel = 2'd0;
    repeat (16) cyc("R5");
    pw2 = 12'd4095; psel = 2'd2; fw0 = 32'hFFF0_0000;
    repeat (16) cyc("R5");
  endtask

  task automatic t_wrap();
    int s0;
    fw0 = 32'h4000_0000; fw1 = '0; fsel = 1'b0;
    pw0 = '0; psel = 2'd0;
    apply_reset();
    repeat (8) cyc("R1");
    s0 = int'(sample);
    repeat (4) cyc("R1");
    check("R1", int'(sample), s0);
    fw0 = 32'hFFFF_F000;
    repeat (40) cyc("R1");
    fw0 = 32'h8000_0001;
    repeat (20) cyc("R1");
  endtask

  task automatic t_fsel();
    fw0 = '0; fw1 = 32'h051E_B852; pw0 = 12'd5; psel = 2'd0;
    apply_reset();
    fsel = 1'b1;
    repeat (20) cyc("R2");
    fsel = 1'b0;
    repeat (10) cyc("R2");
    fw0 = 32'h1234_5679;
    for (int r = 0; r < 8; r++) begin
      fsel = ~fsel;
      repeat (7) cyc("R3");
    end
    fw1 = 32'h2E97_8D50;
    repeat (15) cyc("R3");
  endtask

  task automatic t_latency();
    fw0 = '0; fw1 = '0; fsel = 1'b0;
    pw0 = 12'd0; pw1 = 12'd1024; pw2 = 12'd2048; pw3 = 12'd3072;
    psel = 2'd0;
    apply_reset();
    repeat (8) cyc("R7");
    psel = 2'd1;
    for (int i = 0; i < 6; i++) begin
      cyc("R7");
      check("R7", int'(sample), (i < 5) ? 512 : 1023);
    end
    // a new offset word takes the same path
    pw1 = 12'd3072;
    for (int i = 0; i < 6; i++) begin
      cyc("R7");
      check("R7", int'(sample), (i < 5) ? 1023 : 1);
    end
  endtask

  task automatic t_hold();
    int s0;
    fw0 = 32'h0ABC_1234; fw1 = 32'h3000_0000; fsel = 1'b0;
    pw0 = 12'd100; pw1 = 12'd2000; psel = 2'd0;
    apply_reset();
    repeat (20) cyc("R9");
    hold = 1'b1;
    cyc("R9");
    s0 = int'(sample);
    fsel = 1'b1; psel = 2'd1; fw0 = 32'h7777_0000;
    for (int i = 0; i < 10; i++) begin
      cyc("R9");
      check("R9", int'(sample), s0);
    end
    fsel = 1'b0; psel = 2'd0; fw0 = 32'h0ABC_1234;
    hold = 1'b0;
    repeat (20) cyc("R9");
    for (int i = 0; i < 30; i++) begin
      hold = i[1] & i[0];
      cyc("R9");
    end
    hold = 1'b0;
  endtask

  task automatic t_mix();
    fw0 = 32'h0123_4567; fw1 = 32'h0765_4321;
    apply_reset();
    for (int i = 0; i < 400; i++) begin
      rng = next_rng(rng);
      fsel = rng[0];
      psel = rng[2:1];
      if (rng[7:3] == 5'd0) fw0 = next_rng(rng ^ 32'h55AA_1234);
      if (rng[12:8] == 5'd0) fw1 = next_rng(rng ^ 32'hDEAD_0001);
      pw0 = rng[24:13];
      if (rng[31:29] == 3'd0) pw3 = rng[28:17];
      hold = (rng[27:25] == 3'd7);
      cyc("R3");
    end
    hold = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clear_model();
    t_reset();
    t_phase_select();
    t_wrap();
    t_fsel();
    t_latency();
    t_hold();
    t_mix();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule